// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

This block gathers interrupt request lines from peripherals and tells the processor about them by writing a bus word rather than driving an interrupt wire. Each input line is watched for a rising edge. Every edge sets a sticky bit in a pending register, whatever the mask holds. When the edge falls on a line that is enabled in the mask, the same bit is also set in a request register, and the block queues one 32-bit write on its master port. That write is made up from a programmable interrupt address register. The upper part of the register, with the five lowest bits cleared, is the write address. Those five low bits, zero-extended, are the write data.

Software sees five registers through a simple slave port with address, read and write strobes, and 32-bit data. An error-inhibit bit in the control register stops messages from going out, while pending and request bits keep collecting. Any access to the pending register clears both the pending and the request bits, so the next edge can send a new message. The master port uses a valid/ready handshake. Behind the output slot there is a queue one entry deep.

The recognised source lines are 5, 7, 8, 9, 13, 14, 16 to 21 and 26. Writing mask bits outside that set gives a one-cycle configuration warning. The mask is still updated.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After reset, reads return 0 for request (0x00), mask (0x04), pending (0x08) and control (0x0C). The interrupt address register (0x10) reads IADDR_RST, whose low two bits are 3. msg_valid_o and cfg_bad_o are 0.
- R2: Writes to offset 0x00 have no effect on the request register. Values written to mask (0x04) and interrupt address (0x10) read back unchanged.
- R3: A rising edge on irq_i[n] sets pending bit n whatever the mask holds. A falling edge clears nothing. A line held high sets the bit only once.
- R4: A rising edge on line n with mask bit n set also sets request bit n and raises msg_valid_o one cycle after the edge is sampled. With the mask bit clear, no message is raised.
- R5: A message carries msg_addr_o = iaddr with bits [4:0] forced to 0, and msg_data_o = iaddr[4:0] zero-extended. iaddr is the value of the interrupt address register when the event occurred. While msg_ready_i is low, msg_valid_o and the message fields hold steady.
- R6: While control bit 8 is 1, no message is issued. Pending and request bits are still set.
- R7: A read of pending (0x08) returns its value and then clears pending and request to 0. A write to 0x08 clears both whatever the data.
- R8: A read of control (0x0C) returns only bit 8. All other bits read 0.
- R9: A write to the mask sets cfg_bad_o high for exactly one cycle, the cycle after the write, when the data has any bit outside 0x043F63A0 and is not 0xFFFFFFFF. The value is stored either way.
- R10: If a new message is raised while one is stalled, it waits in a one-entry queue and goes out on the cycle after the stalled one is taken. Further messages in that window are dropped. Their pending and request bits are still set.
- R11: reg_rdata_o is registered and valid in the cycle after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LINES | Peripheral interrupt lines, rising-edge sensitive |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after strobe |
| cfg_bad_o | output | 1 | One-cycle flag for a mask write with unsupported bits |
| msg_valid_o | output | 1 | Interrupt message write request |
| msg_ready_i | input | 1 | Bus accepts the message write |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The bench builds the block with its default parameters: 32 lines, a 5-bit offset and the default valid-source set. This lets it reach every architectural source line, including line 26, as well as the invalid-mask warning for bits outside the set. It keeps the master port stalled so that it can stack an outstanding message, a queued message and a dropped one. Between the first and second message it changes the interrupt address, so each message can be told apart by its address and data.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned SLOT_BITS = 5;
  localparam int unsigned ERR_BIT   = 8;

  localparam int unsigned OFS_REQ   = 'h00;
  localparam int unsigned OFS_MASK  = 'h04;
  localparam int unsigned OFS_PEND  = 'h08;
  localparam int unsigned OFS_CTRL  = 'h0C;
  localparam int unsigned OFS_IADDR = 'h10;

  typedef struct packed {
    logic [REG_W-1:0] addr;
    logic [REG_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/msi_line_latch.sv
module msi_line_latch #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 clr_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 hit_o
);
  logic [NUM_LINES-1:0] irq_q, pend_q, req_q, rise;

  assign rise  = irq_i & ~irq_q;
  assign hit_o = |(rise & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      irq_q  <= irq_i;
      // clear first so an edge in the clearing cycle is kept
      pend_q <= (clr_i ? '0 : pend_q) | rise;
      req_q  <= (clr_i ? '0 : req_q) | (rise & mask_i);
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

  assert_pend_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(pend_q) & ~pend_q) == '0));

  assert_req_in_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q & ~pend_q) == '0);
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out
  import msi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             inhibit_i,
  input  logic [REG_W-1:0] iaddr_i,
  input  logic             ready_i,
  output logic             valid_o,
  output msg_t             msg_o
);
  msg_t new_msg, out_q, que_q;
  logic out_vld_q, que_vld_q, go, out_free;

  assign new_msg.addr = {iaddr_i[REG_W-1:SLOT_BITS], {SLOT_BITS{1'b0}}};
  assign new_msg.data = {{(REG_W-SLOT_BITS){1'b0}}, iaddr_i[SLOT_BITS-1:0]};
  assign go       = fire_i & ~inhibit_i;
  assign out_free = ~out_vld_q | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      que_vld_q <= 1'b0;
      out_q     <= '0;
      que_q     <= '0;
    end else if (out_free) begin
      if (que_vld_q) begin
        out_vld_q <= 1'b1;
        out_q     <= que_q;
        que_vld_q <= go;
        if (go) que_q <= new_msg;
      end else begin
        out_vld_q <= go;
        if (go) out_q <= new_msg;
      end
    end else if (go && !que_vld_q) begin
      que_vld_q <= 1'b1;
      que_q     <= new_msg;
    end
  end

  assign valid_o = out_vld_q;
  assign msg_o   = out_q;

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_q && !ready_i) |=> (out_vld_q && $stable(out_q)));

  assert_msg_format_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_q |-> (out_q.addr[SLOT_BITS-1:0] == '0 &&
                   out_q.data[REG_W-1:SLOT_BITS] == '0));
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter logic [31:0] VALID_LINES = 32'h043F_63A0,
  parameter logic [31:0] IADDR_RST   = 32'hFFFE_0003
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 cfg_bad_o,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 clr_o,
  output logic [REG_W-1:0]     mask_o,
  output logic                 err_o,
  output logic [REG_W-1:0]     iaddr_o
);
  logic [REG_W-1:0] mask_q, iaddr_q, rdata_q, rd_val;
  logic             err_q, bad_q, sel_mask, sel_ctrl, sel_iaddr, sel_pend, bad_val;

  assign sel_mask  = addr_i == ADDR_W'(OFS_MASK);
  assign sel_pend  = addr_i == ADDR_W'(OFS_PEND);
  assign sel_ctrl  = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_iaddr = addr_i == ADDR_W'(OFS_IADDR);
  assign clr_o     = (rd_i | wr_i) & sel_pend;
  assign bad_val   = ((wdata_i & ~VALID_LINES) != '0) && (wdata_i != '1);

  always_comb begin
    rd_val = '0;
    if      (addr_i == ADDR_W'(OFS_REQ)) rd_val = REG_W'(req_i);
    else if (sel_mask)                   rd_val = mask_q;
    else if (sel_pend)                   rd_val = REG_W'(pend_i);
    else if (sel_ctrl)                   rd_val[ERR_BIT] = err_q;
    else if (sel_iaddr)                  rd_val = iaddr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      iaddr_q <= IADDR_RST;
      err_q   <= 1'b0;
      bad_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      bad_q <= wr_i & sel_mask & bad_val;
      if (rd_i) rdata_q <= rd_val;
      if (wr_i) begin
        if (sel_mask)  mask_q  <= wdata_i;
        if (sel_ctrl)  err_q   <= wdata_i[ERR_BIT];
        if (sel_iaddr) iaddr_q <= wdata_i;
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign cfg_bad_o = bad_q;
  assign mask_o    = mask_q;
  assign err_o     = err_q;
  assign iaddr_o   = iaddr_q;

  assert_bad_after_mask_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q |-> $past(wr_i && addr_i == ADDR_W'(OFS_MASK)));
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msi_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter logic [31:0] VALID_LINES = 32'h043F_63A0,
  parameter logic [31:0] IADDR_RST   = 32'hFFFE_0003
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 cfg_bad_o,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [31:0]          msg_addr_o,
  output logic [31:0]          msg_data_o
);
  logic [NUM_LINES-1:0] pend, req;
  logic [REG_W-1:0]     mask, iaddr;
  logic                 clr, err, hit;
  msg_t                 msg;

  msi_regfile #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .VALID_LINES(VALID_LINES), .IADDR_RST(IADDR_RST)
  ) i_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_bad_o,
    .pend_i(pend), .req_i(req), .clr_o(clr),
    .mask_o(mask), .err_o(err), .iaddr_o(iaddr)
  );

  msi_line_latch #(.NUM_LINES(NUM_LINES)) i_latch (
    .clk_i, .rst_ni, .irq_i,
    .mask_i(mask[NUM_LINES-1:0]), .clr_i(clr),
    .pend_o(pend), .req_o(req), .hit_o(hit)
  );

  msi_msg_out i_out (
    .clk_i, .rst_ni, .fire_i(hit), .inhibit_i(err), .iaddr_i(iaddr),
    .ready_i(msg_ready_i), .valid_o(msg_valid_o), .msg_o(msg)
  );

  assign msg_addr_o = msg.addr;
  assign msg_data_o = msg.data;

  assert_no_msg_when_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err && !msg_valid_o && !$past(msg_valid_o)) |=> !msg_valid_o);
endmodule

// File: tb/test_msi_irq_ctrl.sv
module test_msi_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] irq = '0;
  logic [4:0]  addr = '0;
  logic        rd = 0, wr = 0, ready = 0;
  logic [31:0] wdata = '0, rdata, maddr, mdata;
  logic        bad, mvalid;
  int          total = 0, nbad = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_irq_ctrl i_msi_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cfg_bad_o(bad),
    .msg_valid_o(mvalid), .msg_ready_i(ready),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq[n] = 1;
    @(negedge clk); irq[n] = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 valid", {31'b0, mvalid}, 0);
    chk("R1 bad", {31'b0, bad}, 0);
    reg_rd(5'h00, v); chk("R1 req", v, 0);
    reg_rd(5'h04, v); chk("R1 mask", v, 0);
    reg_rd(5'h08, v); chk("R1 pend", v, 0);
    reg_rd(5'h0C, v); chk("R1 ctrl", v, 0);
    reg_rd(5'h10, v); chk("R1 iaddr", v, 32'hFFFE_0003);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    reg_wr(5'h00, 32'hFFFF_FFFF);
    reg_rd(5'h00, v); chk("R2 req ignore", v, 0);
    reg_wr(5'h10, 32'h1234_5677);
    reg_rd(5'h10, v); chk("R2 iaddr", v, 32'h1234_5677);
    reg_rd(5'h14, v); chk("R11 unmapped", v, 0);
    reg_wr(5'h0C, 32'hFFFF_FFFF);
    reg_rd(5'h0C, v); chk("R8 ctrl only bit8", v, 32'h100);
    reg_wr(5'h0C, 32'h0);
  endtask

  task automatic t_mask_check;
    logic [31:0] v;
    @(negedge clk); addr = 5'h04; wdata = 32'h0000_0001; wr = 1;
    @(negedge clk); wr = 0; chk("R9 bad pulse", {31'b0, bad}, 1);
    @(negedge clk); chk("R9 bad one cycle", {31'b0, bad}, 0);
    reg_rd(5'h04, v); chk("R9 stored", v, 32'h1);
    @(negedge clk); addr = 5'h04; wdata = 32'hFFFF_FFFF; wr = 1;
    @(negedge clk); wr = 0; chk("R9 all ones ok", {31'b0, bad}, 0);
    @(negedge clk); addr = 5'h04; wdata = 32'h0000_01A0; wr = 1;
    @(negedge clk); wr = 0; chk("R9 valid ok", {31'b0, bad}, 0);
    reg_rd(5'h04, v); chk("R2 mask", v, 32'h1A0);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    pulse(13);
    chk("R4 no msg masked", {31'b0, mvalid}, 0);
    reg_rd(5'h00, v); chk("R4 req masked", v, 0);
    @(negedge clk); irq[14] = 1;
    repeat (3) @(negedge clk);
    reg_rd(5'h08, v); chk("R3 pend", v, 32'h6000);
    reg_rd(5'h08, v); chk("R3 held no reset", v, 0);
    @(negedge clk); irq[14] = 0;
    @(negedge clk);
    reg_rd(5'h08, v); chk("R3 fall no set", v, 0);
  endtask

  task automatic t_message;
    logic [31:0] v;
    pulse(5);
    chk("R4 valid", {31'b0, mvalid}, 1);
    chk("R5 addr", maddr, 32'h1234_5660);
    chk("R5 data", mdata, 32'h17);
    reg_rd(5'h00, v); chk("R4 req", v, 32'h20);
    repeat (2) @(negedge clk);
    chk("R5 hold valid", {31'b0, mvalid}, 1);
    chk("R5 hold addr", maddr, 32'h1234_5660);
    ready = 1;
    @(negedge clk); ready = 0;
    chk("R5 taken", {31'b0, mvalid}, 0);
    reg_wr(5'h08, 32'h0);
    reg_rd(5'h00, v); chk("R7 write clears req", v, 0);
    reg_rd(5'h08, v); chk("R7 write clears pend", v, 0);
  endtask

  task automatic t_error_inhibit;
    logic [31:0] v;
    reg_wr(5'h0C, 32'h100);
    pulse(8);
    chk("R6 no msg", {31'b0, mvalid}, 0);
    reg_rd(5'h00, v); chk("R6 req kept", v, 32'h100);
    reg_rd(5'h08, v); chk("R7 read pend", v, 32'h100);
    reg_rd(5'h00, v); chk("R7 read clears req", v, 0);
    reg_wr(5'h0C, 32'h0);
  endtask

  task automatic t_queue;
    logic [31:0] v;
    reg_wr(5'h10, 32'h0000_4441);
    pulse(5);
    reg_wr(5'h10, 32'h0000_8882);
    pulse(7);
    reg_wr(5'h10, 32'h0000_CCC3);
    pulse(8);
    chk("R10 first out", maddr, 32'h4440);
    reg_rd(5'h08, v); chk("R10 pend all", v, 32'h1A0);
    @(negedge clk); ready = 1;
    @(negedge clk);
    chk("R10 queued valid", {31'b0, mvalid}, 1);
    chk("R10 queued addr", maddr, 32'h8880);
    chk("R10 queued data", mdata, 32'h2);
    @(negedge clk);
    chk("R10 third dropped", {31'b0, mvalid}, 0);
    ready = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mask_check();
    t_edges();
    t_message();
    t_error_inhibit();
    t_queue();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, nbad);
    $finish;
  end
endmodule